// File: doc/BRIEF.md
# Triggered Waveform Table Streaming Channel

This block is one DMA-style channel that plays a stored waveform into a fixed output register, typically the data register of a DAC. Every trigger event copies exactly one 32-bit sample: the channel reads the word at its current source address from the sample memory, then writes it with a strobe to a destination address that never changes. After each copy the source pointer moves forward by one word (4 bytes) and the remaining-transfer counter drops by one. When the counter runs out, the channel raises a one-cycle interrupt. If reload is enabled, it restores the start address and count so the waveform repeats without a gap. If reload is off, the channel turns itself off.

Triggers come from one of two places. The first is an internal period generator: a counter whose period is a programmable divide value, with a square output whose falling edge is the trigger event. The second is an external one-cycle trigger input. To produce a tone of frequency F from a table of L points, the event rate must be L times F; with a 256-point table, 25 600 events per second give 100 Hz. Software programs addresses, count and divider first, then sets the enable bit. Each write to the control register restarts the pass from the start address.

Config registers, selected by `cfg_addr`: 0 = control (bit0 enable, bit1 reload, bit2 external trigger select), 1 = source start byte address, 2 = destination byte address, 3 = transfer count, 4 = divide value.

Top module: `table_dac_dma`

## Requirements
- R1: After reset, `mem_re`, `out_we`, `irq` and `pwm_out` are 0, the channel is disabled, the divide value is 0 and the transfer count is 256.
- R2: With a divide value N of 2 or more, `pwm_out` is high for the first floor(N/2) cycles of every N-cycle period. Its falling edge is the internal trigger event, so internally triggered transfers are exactly N cycles apart.
- R3: A divide value of 0 (and likewise 1) produces no trigger events: `pwm_out` stays low and no transfer occurs.
- R4: Each trigger event on an enabled channel produces one read of `mem_addr` (`mem_re`), and in the next cycle one `out_we` pulse. That pulse carries the word returned by the memory and the programmed destination on `out_addr`.
- R5: Successive transfers of a pass read consecutive words, starting at the source start address, with the address advancing by 4 bytes per transfer.
- R6: `irq` is a one-cycle pulse coincident with the `out_we` of the last transfer of a pass, and is never high at any other time.
- R7: With reload set, the transfer after the last one reads the source start address again and a full new count begins, so the sample sequence wraps with no missing or repeated entry.
- R8: With reload clear, the channel disables itself after the last transfer, and later triggers produce no transfers until control is written again.
- R9: Triggers are ignored while the channel is disabled. A pass started by a control write begins at the source start address.
- R10: A trigger that arrives while an earlier one is still waiting to be issued adds nothing. Three triggers on consecutive cycles yield exactly two transfers.
- R11: Control bit2 = 1 selects `ext_trig` as the trigger and ignores the internal generator. Bit2 = 0 selects the generator and ignores `ext_trig`.
- R12: The pass length equals the programmed transfer count: `irq` occurs once every count transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 3 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| mem_re | output | 1 | Sample memory read request |
| mem_addr | output | 16 | Sample memory byte address |
| mem_rdata | input | 32 | Sample memory read data, valid one cycle after `mem_re` |
| out_we | output | 1 | Output register write strobe |
| out_addr | output | 16 | Output register byte address |
| out_data | output | 32 | Output register write data |
| ext_trig | input | 1 | External one-cycle trigger event |
| pwm_out | output | 1 | Period generator square output |
| irq | output | 1 | Pass-complete pulse |

## Verification
Widely spaced external triggers with random counts, addresses and reload settings show that each event moves one word in table order and wraps or stops at the right transfer. Three back-to-back trigger cycles separate merging of pending events from counting every event. Internal generator runs with several divide values, including 0, tell the falling-edge event rate apart from the period and from a stopped timer. Runs in each source mode show that the unselected trigger has no effect. A full default-length pass with reload confirms the 256-entry wrap.

// File: rtl/table_dac_dma.sv
module table_dac_dma #(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 256,
  parameter int DIVW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_we,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic          ext_trig,
  output logic          pwm_out,
  output logic          irq
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int STEP = DW / 8;

  logic            en_q, rld_q, ext_q, pend_q, rd_q, pwm_d;
  logic [AW-1:0]   src_q, dst_q, cur_q;
  logic [CW-1:0]   cnt_q, left_q;
  logic [DIVW-1:0] div_q, tcnt;
  logic            ctrl_wr, cmp_evt, trig, last;

  assign ctrl_wr  = cfg_we && cfg_addr == 3'd0;
  assign pwm_out  = (div_q != '0) && (tcnt < (div_q >> 1));
  assign cmp_evt  = pwm_d && !pwm_out;
  assign trig     = ext_q ? ext_trig : cmp_evt;
  assign mem_re   = en_q && pend_q && !rd_q && (left_q != '0);
  assign mem_addr = cur_q;
  assign out_we   = rd_q;
  assign out_addr = dst_q;
  assign out_data = mem_rdata;
  assign last     = rd_q && (left_q == CW'(1));
  assign irq      = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= CW'(DEPTH);
      div_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd1: src_q <= cfg_wdata[AW-1:0];
        3'd2: dst_q <= cfg_wdata[AW-1:0];
        3'd3: cnt_q <= cfg_wdata[CW-1:0];
        3'd4: div_q <= cfg_wdata[DIVW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      pwm_d <= 1'b0;
    end else begin
      pwm_d <= pwm_out;
      if ((cfg_we && cfg_addr == 3'd4) || div_q == '0 || tcnt >= div_q - DIVW'(1))
        tcnt <= '0;
      else
        tcnt <= tcnt + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rld_q  <= 1'b0;
      ext_q  <= 1'b0;
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
    end else if (ctrl_wr) begin
      en_q   <= cfg_wdata[0];
      rld_q  <= cfg_wdata[1];
      ext_q  <= cfg_wdata[2];
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
      cur_q  <= src_q;
      left_q <= cnt_q;
    end else begin
      rd_q <= mem_re;
      if (en_q && trig)
        pend_q <= 1'b1;
      else if (mem_re)
        pend_q <= 1'b0;
      if (rd_q) begin
        if (last) begin
          cur_q  <= src_q;
          left_q <= cnt_q;
          if (!rld_q) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
          end
        end else begin
          cur_q  <= cur_q + AW'(STEP);
          left_q <= left_q - CW'(1);
        end
      end
    end
  end

  p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !ctrl_wr) |=> out_we);
  p_src_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && !irq && !cfg_we) |=> (mem_addr == $past(mem_addr) + AW'(STEP)));
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_reload_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && rld_q && !cfg_we) |=> (mem_addr == src_q));
  p_stop_after_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rld_q && !cfg_we) |=> !en_q);
  p_no_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> !out_we);
  p_timer_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && $past(div_q) == '0) |-> !pwm_d);
endmodule

// File: tb/table_dac_dma_bench.sv
module table_dac_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_re;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        out_we;
  logic [15:0] out_addr;
  logic [31:0] out_data;
  logic        ext_trig = 1'b0;
  logic        pwm_out;
  logic        irq;

  int checks = 0, errors = 0;
  int cyc = 0;
  int exp_idx = 0, exp_cnt = 256;
  int exp_src = 0, exp_dst = 0;
  int n_we = 0, n_irq = 0, n_re = 0;
  int last_cyc = -1, min_iv = 1 << 30, max_iv = 0;

  table_dac_dma u_table_dac_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_we(out_we), .out_addr(out_addr), .out_data(out_data),
    .ext_trig(ext_trig), .pwm_out(pwm_out), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] sample(input int w);
    return (32'(w) * 32'h9E3779B1) ^ 32'hA5A5_0000;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) mem_rdata <= sample(int'(mem_addr) >> 2);
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re) n_re++;
      if (out_we) begin
        chk(out_data == sample((exp_src >> 2) + exp_idx), "R5", "sample data", out_data, sample((exp_src >> 2) + exp_idx));
        chk(out_addr == 16'(exp_dst), "R4", "destination", out_addr, exp_dst);
        chk(irq == (exp_idx == exp_cnt - 1), "R6", "irq at pass end", irq, exp_idx == exp_cnt - 1);
        n_we++;
        if (irq) n_irq++;
        if (last_cyc >= 0) begin
          if (cyc - last_cyc < min_iv) min_iv = cyc - last_cyc;
          if (cyc - last_cyc > max_iv) max_iv = cyc - last_cyc;
        end
        last_cyc = cyc;
        exp_idx = (exp_idx == exp_cnt - 1) ? 0 : exp_idx + 1;
      end else if (irq) begin
        chk(1'b0, "R6", "irq without write", 1, 0);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: exp_idx = 0;
      1: exp_src = d;
      2: exp_dst = d;
      3: exp_cnt = d;
      default: ;
    endcase
  endtask

  task automatic trig(input int gap);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic clr_iv();
    last_cyc = -1; min_iv = 1 << 30; max_iv = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base, hi, d, c, nt, w0, i0, r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!out_we && !irq && !mem_re && !pwm_out, "R1", "idle outputs in reset", {out_we, irq, mem_re, pwm_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_we && !irq && !mem_re && !pwm_out, "R1", "idle after reset", {out_we, irq, mem_re, pwm_out}, 0);
    trig(3);
    chk(n_we == 0 && n_re == 0, "R1", "disabled after reset", n_we, 0);

    // R12 R7: default 256-entry pass with reload, wraps without gap
    wr(1, 32'h1000); wr(2, 32'h0040);
    wr(0, 7);
    for (int k = 0; k < 259; k++) trig(2);
    repeat (4) @(negedge clk);
    chk(n_we == 259, "R12", "transfers in default pass", n_we, 259);
    chk(n_irq == 1, "R7", "one wrap in 259 transfers", n_irq, 1);

    // R10: three consecutive trigger cycles merge into two transfers
    wr(0, 7);
    w0 = n_we;
    @(negedge clk); ext_trig = 1'b1;
    repeat (3) @(negedge clk);
    ext_trig = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_we - w0 == 2, "R10", "merged triggers", n_we - w0, 2);

    // R8: no reload, channel stops after count
    wr(3, 3); wr(0, 5);
    w0 = n_we; i0 = n_irq;
    for (int k = 0; k < 6; k++) trig(3);
    chk(n_we - w0 == 3, "R8", "transfers before stop", n_we - w0, 3);
    chk(n_irq - i0 == 1, "R8", "single irq", n_irq - i0, 1);

    // R9: disabled ignores triggers, restart begins at entry 0
    wr(0, 4);
    w0 = n_we; i0 = n_re;
    for (int k = 0; k < 4; k++) trig(2);
    chk(n_we == w0 && n_re == i0, "R9", "disabled channel quiet", n_we - w0, 0);
    wr(0, 5);
    trig(4);
    chk(n_we - w0 == 1, "R9", "first transfer after enable", n_we - w0, 1);

    // R2: internal generator, divide 8
    wr(3, 256); wr(0, 0); wr(4, 8);
    hi = 0;
    for (int k = 0; k < 160; k++) begin if (pwm_out) hi++; @(negedge clk); end
    chk(hi == 80, "R2", "pwm high cycles div 8", hi, 80);
    clr_iv(); w0 = n_we;
    wr(0, 3);
    repeat (100) @(negedge clk);
    chk(min_iv == 8 && max_iv == 8, "R2", "transfer spacing div 8", max_iv, 8);
    // R11: internal mode ignores ext_trig, ext mode ignores generator
    w0 = n_we;
    @(negedge clk); ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    repeat (6) @(negedge clk);
    chk(n_we - w0 <= 1, "R11", "ext_trig ignored in internal mode", n_we - w0, 1);
    wr(0, 7); w0 = n_we;
    repeat (80) @(negedge clk);
    chk(n_we == w0, "R11", "generator ignored in external mode", n_we - w0, 0);

    // R3: divide 0 stops generator
    wr(4, 0); wr(0, 3); w0 = n_we; hi = 0;
    for (int k = 0; k < 100; k++) begin if (pwm_out) hi++; @(negedge clk); end
    chk(hi == 0 && n_we == w0, "R3", "stopped generator", hi + n_we - w0, 0);

    // R2 random divide values
    for (int k = 0; k < 6; k++) begin
      d = 2 + int'($urandom % 19);
      wr(0, 0); wr(4, d);
      hi = 0;
      for (int j = 0; j < d * 10; j++) begin if (pwm_out) hi++; @(negedge clk); end
      chk(hi == (d / 2) * 10, "R2", "pwm duty random divide", hi, (d / 2) * 10);
      clr_iv(); wr(0, 3);
      repeat (d * 6 + 4) @(negedge clk);
      chk(min_iv == d && max_iv == d, "R2", "spacing random divide", max_iv, d);
    end
    wr(0, 0); wr(4, 0);

    // R4 R5 R12 random passes on external trigger
    for (int k = 0; k < 20; k++) begin
      c = 1 + int'($urandom % 6);
      base = int'($urandom % 1024) * 4;
      r = int'($urandom % 2);
      nt = 1 + int'($urandom % 14);
      wr(1, base); wr(2, int'($urandom % 65536)); wr(3, c);
      wr(0, 5 | (r << 1));
      w0 = n_we; i0 = n_irq;
      for (int j = 0; j < nt; j++) trig(1 + int'($urandom % 4));
      repeat (3) @(negedge clk);
      chk(n_we - w0 == (r ? nt : (nt < c ? nt : c)), "R12", "random pass transfers", n_we - w0, r ? nt : (nt < c ? nt : c));
      chk(n_irq - i0 == (r ? nt / c : (nt >= c ? 1 : 0)), "R6", "random pass irqs", n_irq - i0, r ? nt / c : (nt >= c ? 1 : 0));
    end
    finish_run();
  end
endmodule